// File: doc/BRIEF.md
# Dual-Function Parallel Port Register Block

This block holds the configuration and output state of a 16-bit parallel port. Each bit can be a general-purpose pin or can be handed to a dedicated peripheral function. There are three registers. The data register latches the output values. The direction register makes each bit an input or an output. The function-select register decides whether a bit is general-purpose or dedicated. Software reaches these registers through a small synchronous bus with one write-enable per byte lane.

On the pin side, the block drives output values and output enables for the general-purpose output bits. It accepts two input vectors: the live pin levels and the inputs of the dedicated functions. Both pass through a two-flop synchronizer. A read of the data register returns a per-bit blend of three sources, chosen by that bit's direction and function-select settings. Lanes that the access does not enable read as zero.

Top module: `gpio_dualfn_port`

## Requirements
- R1: After reset, all three registers read 0, and `pin_oe` and `pin_out` are all zero, so every bit starts as a general-purpose input.
- R2: A write updates only the bytes whose `bus_be` bit is 1 (bit 0 covers data bits 7:0, bit 1 covers bits 15:8). Addresses: 0 is data, 1 is direction, 2 is function-select.
- R3: A data read of a bit with direction 1 and function-select 0 returns the latched data value, whatever the pin level.
- R4: A data read of a bit with direction 0 and function-select 0 returns the synchronized `pin_in` level.
- R5: A data read of a bit with direction 0 and function-select 1 returns the synchronized `fn_in` level.
- R6: A data read of a bit with direction 1 and function-select 1 returns 0.
- R7: A data-register write updates the latch even for bits that are currently inputs. The value appears once the bit is made an output.
- R8: Read data is zero in every byte lane whose `bus_be` bit is 0, for every address.
- R9: `pin_oe` is 1 exactly for bits with direction 1 and function-select 0. `pin_out` carries the latched data on those bits and 0 on all others.
- R10: A change on `pin_in` or `fn_in` is not seen by reads registered at the first two rising edges after the change. It is seen from the third edge on.
- R11: Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register address |
| bus_be | input | 2 | Byte-lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered one cycle after the read; held between reads |
| pin_in | input | 16 | Pin levels, asynchronous |
| fn_in | input | 16 | Dedicated-function inputs, asynchronous |
| pin_out | output | 16 | Output values for the general-purpose output bits |
| pin_oe | output | 16 | Output enables |

## Verification
The assertions assume that bus signals are steady around the rising edge and that `bus_sel` is never left undefined after reset. The bench drives every input on the falling edge and samples on the falling edge, which keeps within that assumption. The assertions also take pin timing for granted only through the synchronizer. For this reason the bench changes `pin_in` and `fn_in` and then waits at least three cycles before it checks the read data. The single exception is the test for R10, which samples each edge in turn.

// File: rtl/gpio_dualfn_port.sv
module gpio_dualfn_port #(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [WIDTH/8-1:0] bus_be,
  input  logic [WIDTH-1:0]   bus_wdata,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   pin_in,
  input  logic [WIDTH-1:0]   fn_in,
  output logic [WIDTH-1:0]   pin_out,
  output logic [WIDTH-1:0]   pin_oe
);
  localparam int LANES = WIDTH / 8;
  localparam logic [1:0] A_DAT = 2'd0;
  localparam logic [1:0] A_DIR = 2'd1;
  localparam logic [1:0] A_FSL = 2'd2;

  logic [WIDTH-1:0] dat_q, dir_q, fsel_q;
  logic [WIDTH-1:0] pin_s1, pin_s2, fn_s1, fn_s2;
  logic [WIDTH-1:0] lane_m, gp_m, port_view, rd_mux;
  logic             wr_go, rd_go;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_m[g*8 +: 8] = {8{bus_be[g]}};
  end

  assign wr_go = bus_sel & bus_wr;
  assign rd_go = bus_sel & ~bus_wr;
  assign gp_m  = ~fsel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_q  <= '0;
      dir_q  <= '0;
      fsel_q <= '0;
    end else if (wr_go) begin
      case (bus_addr)
        A_DAT:   dat_q  <= (dat_q  & ~lane_m) | (bus_wdata & lane_m);
        A_DIR:   dir_q  <= (dir_q  & ~lane_m) | (bus_wdata & lane_m);
        A_FSL:   fsel_q <= (fsel_q & ~lane_m) | (bus_wdata & lane_m);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
      fn_s1  <= '0;
      fn_s2  <= '0;
    end else begin
      pin_s1 <= pin_in;
      pin_s2 <= pin_s1;
      fn_s1  <= fn_in;
      fn_s2  <= fn_s1;
    end
  end

  assign port_view = (dat_q  &  dir_q & gp_m)
                   | (pin_s2 & ~dir_q & gp_m)
                   | (fn_s2  & ~dir_q & fsel_q);

  always_comb begin
    case (bus_addr)
      A_DAT:   rd_mux = port_view;
      A_DIR:   rd_mux = dir_q;
      A_FSL:   rd_mux = fsel_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_go) bus_rdata <= rd_mux & lane_m;
  end

  assign pin_oe  = dir_q & gp_m;
  assign pin_out = dat_q & dir_q & gp_m;

  AST_WR_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && bus_addr == A_DIR) |=> (((dir_q ^ $past(dir_q)) & ~$past(lane_m)) == '0)); // R2
  AST_GP_OUT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && bus_addr == A_DAT) |=>
      (((bus_rdata ^ $past(dat_q)) & $past(dir_q & gp_m & lane_m)) == '0)); // R3
  AST_DED_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && bus_addr == A_DAT) |=> ((bus_rdata & $past(dir_q & fsel_q)) == '0)); // R6
  AST_RD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> ((bus_rdata & ~$past(lane_m)) == '0)); // R8
  AST_OE_DEDICATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && bus_addr == A_FSL) |=> ((pin_oe & $past(bus_wdata & lane_m)) == '0)); // R9
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && bus_addr == 2'd3) |=> ($stable(dat_q) && $stable(dir_q) && $stable(fsel_q))); // R11
endmodule

// File: tb/tb_gpio_dualfn_port.sv
module tb_gpio_dualfn_port;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [1:0]  bus_be = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in = 0, fn_in = 0;
  logic [15:0] pin_out, pin_oe;

  int total = 0, bad = 0;
  logic [15:0] m_dat = 0, m_dir = 0, m_fsl = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_dualfn_port #(.WIDTH(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .fn_in(fn_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  function automatic logic [15:0] lanes(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    case (a)
      2'd0: m_dat = (m_dat & ~lanes(be)) | (d & lanes(be));
      2'd1: m_dir = (m_dir & ~lanes(be)) | (d & lanes(be));
      2'd2: m_fsl = (m_fsl & ~lanes(be)) | (d & lanes(be));
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, input logic [1:0] be, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 0;
    v = bus_rdata;
  endtask

  function automatic logic [15:0] view(input logic [15:0] p, input logic [15:0] f);
    return (m_dat & m_dir & ~m_fsl) | (p & ~m_dir & ~m_fsl) | (f & ~m_dir & m_fsl);
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v1, v2, v3;
    logic [15:0] dirs [4];
    logic [15:0] fsls [4];
    logic [15:0] pins [2];
    logic [15:0] fns  [2];
    dirs = '{16'h0000, 16'hFFFF, 16'h00FF, 16'hA5C3};
    fsls = '{16'h0000, 16'hFFFF, 16'h0F0F, 16'h3C96};
    pins = '{16'h1234, 16'hEDCB};
    fns  = '{16'h9A6E, 16'h6591};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 16'h0);
    check("R1 pin_out", pin_out, 16'h0);
    rd(2'd0, 2'b11, v); check("R1 data", v, 16'h0);
    rd(2'd1, 2'b11, v); check("R1 dir", v, 16'h0);
    rd(2'd2, 2'b11, v); check("R1 fsel", v, 16'h0);

    // R2 byte-lane writes
    wr(2'd1, 2'b01, 16'hBEEF);
    rd(2'd1, 2'b11, v); check("R2 low lane", v, 16'h00EF);
    wr(2'd1, 2'b10, 16'h1234);
    rd(2'd1, 2'b11, v); check("R2 high lane", v, 16'h12EF);
    wr(2'd2, 2'b00, 16'hFFFF);
    rd(2'd2, 2'b11, v); check("R2 no lane", v, 16'h0000);
    wr(2'd1, 2'b11, 16'h0000);

    // R7 latch updates while input
    wr(2'd0, 2'b11, 16'hC3A5);
    check("R7 oe stays off", pin_oe, 16'h0);
    wr(2'd1, 2'b11, 16'hFFFF);
    rd(2'd0, 2'b11, v); check("R7 latch visible", v, 16'hC3A5);
    check("R7 pin_out", pin_out, 16'hC3A5);

    // R11 unmapped address
    wr(2'd3, 2'b11, 16'h0000);
    rd(2'd3, 2'b11, v); check("R11 read zero", v, 16'h0);
    rd(2'd1, 2'b11, v); check("R11 dir kept", v, 16'hFFFF);
    rd(2'd0, 2'b11, v); check("R11 dat kept", v, 16'hC3A5);

    // R10 synchronizer latency
    wr(2'd1, 2'b11, 16'h0000);
    pin_in = 16'h0F0F;
    repeat (4) @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 2'd0; bus_be = 2'b11;
    pin_in = 16'hF0F0;
    @(negedge clk); v1 = bus_rdata;
    @(negedge clk); v2 = bus_rdata;
    @(negedge clk); v3 = bus_rdata;
    bus_sel = 0;
    check("R10 edge1 old", v1, 16'h0F0F);
    check("R10 edge2 old", v2, 16'h0F0F);
    check("R10 edge3 new", v3, 16'hF0F0);

    // Sweep over configurations, pins and byte lanes
    wr(2'd0, 2'b11, 16'h5AA5);
    foreach (dirs[i]) begin
      foreach (fsls[j]) begin
        wr(2'd1, 2'b11, dirs[i]);
        wr(2'd2, 2'b11, fsls[j]);
        // R9 enables and outputs
        check("R9 pin_oe", pin_oe, dirs[i] & ~fsls[j]);
        check("R9 pin_out", pin_out, m_dat & dirs[i] & ~fsls[j]);
        foreach (pins[k]) begin
          pin_in = pins[k];
          fn_in  = fns[k];
          repeat (3) @(negedge clk);
          for (int b = 0; b < 4; b++) begin
            rd(2'd0, b[1:0], v);
            // R3 R4 R5 R6 R8 per-bit source selection with lane masking
            check("R3 R4 R5 R6 R8 data read", v, view(pins[k], fns[k]) & lanes(b[1:0]));
          end
          rd(2'd2, 2'b01, v);
          check("R8 fsel low lane", v, fsls[j] & 16'h00FF);
        end
      end
    end

    // Dedicated output bits read zero in isolation
    wr(2'd1, 2'b11, 16'hFFFF);
    wr(2'd2, 2'b11, 16'hFFFF);
    wr(2'd0, 2'b11, 16'hFFFF);
    pin_in = 16'hFFFF; fn_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    rd(2'd0, 2'b11, v); check("R6 dedicated output", v, 16'h0);
    check("R9 no oe on dedicated", pin_oe, 16'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule